// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block converts one pulse-width command into two mutually exclusive gate enables for a synchronous step-down power stage: one for the high-side switch and one for the low-side switch. It does not insert a fixed delay between the two. It waits for two comparator flags from the analog side. One flag says that the switch node has dropped below roughly 2 V. The other says that the low-side gate has discharged below roughly 1 V. Both flags are asynchronous, so each passes through its own synchronizer before the state machine acts on it.

If the switch node stays high after the high side turns off, a timeout counter turns the low side on anyway. This happens when inductor current flows backwards, and the low side must then carry that current. A soft-start hold keeps the low side off until the first high command arrives, which protects a pre-charged output from being pulled down. Protection logic has two overrides. It can demand the low side as if the command were low, which also bypasses the soft-start hold. It can also tristate both switches at once.

Top module: `dt_gate_sequencer`

## Requirements
- R1: When `pwm_cmd` is low while the high side is on, `hi_gate_en` drops at the next clock edge. `lo_gate_en` rises only on the third edge after `sw_node_low` goes high, which allows for two synchronizer stages and the state register.
- R2: When `pwm_cmd` is high while the low side is on, `lo_gate_en` drops at the next clock edge. `hi_gate_en` rises only on the third edge after `lo_gate_low` goes high.
- R3: If `sw_node_low` stays low, `lo_gate_en` rises exactly `WD_CYCLES` clock edges after the edge that cleared `hi_gate_en`, provided `pwm_cmd` stays low.
- R4: While `ss_hold` is high, the low side stays off until `pwm_cmd` has been high at least once during that hold. Raising `ss_hold` again re-arms the hold, and an active low side then turns off at the next edge.
- R5: `prot_force_lo` acts as a low command whatever `pwm_cmd` is, and it overrides the soft-start hold. The switch-node handshake of R1 still applies.
- R6: `prot_tristate` high clears both outputs in the same cycle, before any clock edge, and overrides every other input. After it is released, the sequencer restarts from the all-off state.
- R7: `hi_gate_en` and `lo_gate_en` are never high together.
- R8: A command held high keeps the high side on indefinitely, and a command held low keeps the low side on indefinitely. This covers duty cycles of 100 % and 0 %.
- R9: Synchronous active-low reset clears both outputs and returns the sequencer to the all-off state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_cmd | input | 1 | Modulator command, 1 = high side wanted |
| sw_node_low | input | 1 | Comparator flag: switch node below about 2 V (asynchronous) |
| lo_gate_low | input | 1 | Comparator flag: low-side gate below about 1 V (asynchronous) |
| ss_hold | input | 1 | Soft-start hold: keep the low side off until the first high command |
| prot_force_lo | input | 1 | Protection demand for the low side; overrides the hold |
| prot_tristate | input | 1 | Protection demand to turn both switches off |
| hi_gate_en | output | 1 | High-side gate enable |
| lo_gate_en | output | 1 | Low-side gate enable |

## Verification
Timing of each result:
- A turn-off caused by a change in `pwm_cmd` appears one edge later.
- A turn-on that waits on a comparator flag appears three edges after the flag changes.
- The timeout turn-on appears `WD_CYCLES` edges after the high side goes off, which is `WD_CYCLES + 1` edges after the command falls.
- The tristate override acts within the same cycle.

How the bench keeps to this timing:
- It drives inputs on the falling clock edge.
- It counts exactly the number of rising edges each result needs, then samples on the next falling edge.
- For every handshake and for the timeout, it also samples one edge early to prove the enable has not arrived too soon.
- Tristate is sampled one time unit after it is driven, with no rising edge in between.

// File: rtl/gseq_pkg.sv
// Shared types for the adaptive dead-time gate sequencer.
package gseq_pkg;

    // Sequencer states; only GS_HI and GS_LO drive a gate.
    typedef enum logic [2:0] {
        GS_IDLE    = 3'd0,  // both switches off
        GS_HI      = 3'd1,  // high side conducting
        GS_FALL_DT = 3'd2,  // high side off, waiting on switch node or timeout
        GS_LO      = 3'd3,  // low side conducting
        GS_RISE_DT = 3'd4   // low side off, waiting on low-side gate discharge
    } gs_state_t;

endpackage

// File: rtl/gseq_flag_sync.sv
// Multi-stage synchronizer for one asynchronous comparator flag.
// Assumes STAGES >= 1; output lags input by STAGES rising edges.
module gseq_flag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= din;
            end
        end else begin : g_chain
            // Shift the flag through the register chain.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/gseq_ss_gate.sv
// Soft-start low-side permission.
// While ss_hold is high, the low side is blocked until pwm_cmd has been
// seen high during that hold. A protection low-side demand bypasses the block.
module gseq_ss_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_hold,
    input  logic pwm_cmd,
    input  logic force_lo,
    output logic lo_permit
);

    logic pulse_seen_q;

    // Remember the first high command of the current hold; forget it when the hold ends.
    always_ff @(posedge clk) begin
        if (!rst_n)       pulse_seen_q <= 1'b0;
        else if (ss_hold) pulse_seen_q <= pulse_seen_q | pwm_cmd;
        else              pulse_seen_q <= 1'b0;
    end

    // Low side allowed outside the hold, after the first pulse, or on protection demand.
    always_comb begin
        lo_permit = force_lo | ~ss_hold | pulse_seen_q;
    end

endmodule

// File: rtl/gseq_wdog.sv
// Timeout for the falling-edge handshake.
// Counts clocks while armed and clears when disarmed. Expires on the
// WD_CYCLES-th edge after arming. Assumes WD_CYCLES >= 2.
module gseq_wdog #(
    parameter int WD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);

    localparam int CW = $clog2(WD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WD_CYCLES - 1);
    localparam logic [CW-1:0] TOP  = CW'(WD_CYCLES);

    logic [CW-1:0] cnt_q;

    // Count armed cycles, saturating at WD_CYCLES.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (!arm)        cnt_q <= '0;
        else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
    end

    // Expiry flag for the state machine.
    always_comb begin
        expired = arm && (cnt_q >= LAST);
    end

endmodule

// File: rtl/gseq_fsm.sv
// Break-before-make state machine.
// Inputs are already synchronous. The gate enables decode the state,
// and both are gated by the tristate override so that it acts within the cycle.
module gseq_fsm
    import gseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pwm_cmd,
    input  logic      force_lo,
    input  logic      tristate,
    input  logic      sw_low_s,
    input  logic      lsg_low_s,
    input  logic      lo_permit,
    input  logic      wd_expired,
    output gs_state_t state,
    output logic      hi_en,
    output logic      lo_en
);

    gs_state_t state_q, state_d;
    logic      want_hi;

    // Effective command: a protection low-side demand beats the modulator.
    always_comb begin
        want_hi = pwm_cmd & ~force_lo;
    end

    // Next-state decode with tristate as top priority.
    always_comb begin
        state_d = state_q;
        case (state_q)
            GS_IDLE: begin
                if (want_hi)        state_d = GS_RISE_DT;
                else if (lo_permit) state_d = GS_FALL_DT;
            end
            GS_HI: begin
                if (!want_hi)       state_d = GS_FALL_DT;
            end
            GS_FALL_DT: begin
                if (want_hi)                      state_d = GS_RISE_DT;
                else if (sw_low_s || wd_expired)  state_d = lo_permit ? GS_LO : GS_IDLE;
            end
            GS_LO: begin
                if (want_hi)        state_d = GS_RISE_DT;
                else if (!lo_permit) state_d = GS_IDLE;
            end
            GS_RISE_DT: begin
                if (!want_hi)       state_d = GS_FALL_DT;
                else if (lsg_low_s) state_d = GS_HI;
            end
            default:                state_d = GS_IDLE;
        endcase
        if (tristate) state_d = GS_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GS_IDLE;
        else        state_q <= state_d;
    end

    // Gate enables decoded from state and masked by tristate.
    always_comb begin
        hi_en = (state_q == GS_HI) && !tristate;
        lo_en = (state_q == GS_LO) && !tristate;
    end

    assign state = state_q;

endmodule

// File: rtl/dt_gate_sequencer.sv
// Adaptive dead-time gate sequencer, top level.
// Synchronizes the two comparator flags, derives soft-start permission,
// and runs the timeout counter while waiting for the switch node.
// Assumes pwm_cmd and the protection inputs are already synchronous to clk.
module dt_gate_sequencer
    import gseq_pkg::*;
#(
    parameter int WD_CYCLES   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_cmd,
    input  logic sw_node_low,
    input  logic lo_gate_low,
    input  logic ss_hold,
    input  logic prot_force_lo,
    input  logic prot_tristate,
    output logic hi_gate_en,
    output logic lo_gate_en
);

    logic      sw_low_s;
    logic      lsg_low_s;
    logic      lo_permit;
    logic      wd_expired;
    logic      wd_arm;
    gs_state_t state;

    gseq_flag_sync #(.STAGES(SYNC_STAGES)) u_sync_sw (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sw_node_low),
        .dout (sw_low_s)
    );

    gseq_flag_sync #(.STAGES(SYNC_STAGES)) u_sync_lsg (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (lo_gate_low),
        .dout (lsg_low_s)
    );

    gseq_ss_gate u_ss (
        .clk      (clk),
        .rst_n    (rst_n),
        .ss_hold  (ss_hold),
        .pwm_cmd  (pwm_cmd),
        .force_lo (prot_force_lo),
        .lo_permit(lo_permit)
    );

    // The timeout runs only while waiting for the switch node to fall.
    always_comb begin
        wd_arm = (state == GS_FALL_DT);
    end

    gseq_wdog #(.WD_CYCLES(WD_CYCLES)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (wd_arm),
        .expired(wd_expired)
    );

    gseq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_cmd   (pwm_cmd),
        .force_lo  (prot_force_lo),
        .tristate  (prot_tristate),
        .sw_low_s  (sw_low_s),
        .lsg_low_s (lsg_low_s),
        .lo_permit (lo_permit),
        .wd_expired(wd_expired),
        .state     (state),
        .hi_en     (hi_gate_en),
        .lo_en     (lo_gate_en)
    );

endmodule

// File: rtl/gseq_checker.sv
// Port-level properties of the gate sequencer, bound to the top module.
module gseq_checker (
    input logic clk,
    input logic rst_n,
    input logic pwm_cmd,
    input logic prot_force_lo,
    input logic prot_tristate,
    input logic hi_gate_en,
    input logic lo_gate_en
);

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_gate_en && lo_gate_en));                                        // R7

    AST_HI_DROPS_ON_LOW_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_gate_en && !pwm_cmd) |=> !hi_gate_en);                           // R1

    AST_LO_AFTER_HI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_gate_en) |-> !$past(hi_gate_en));                           // R1

    AST_LO_DROPS_ON_HIGH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_gate_en && pwm_cmd && !prot_force_lo) |=> !lo_gate_en);          // R2

    AST_HI_AFTER_LO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_gate_en) |-> !$past(lo_gate_en));                           // R2

    AST_TRISTATE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(prot_tristate) |-> (!hi_gate_en && !lo_gate_en));              // R6

endmodule

bind dt_gate_sequencer gseq_checker u_gseq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwm_cmd      (pwm_cmd),
    .prot_force_lo(prot_force_lo),
    .prot_tristate(prot_tristate),
    .hi_gate_en   (hi_gate_en),
    .lo_gate_en   (lo_gate_en)
);

// File: tb/dt_gate_sequencer_test.sv
// Self-checking bench for the adaptive dead-time gate sequencer.
module dt_gate_sequencer_test;

    localparam int WD  = 12;
    localparam int NV  = 20;
    localparam int SETTLE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_cmd = 1'b0, sw_node_low = 1'b1, lo_gate_low = 1'b1;
    logic ss_hold = 1'b0, prot_force_lo = 1'b0, prot_tristate = 1'b0;
    logic hi, lo;

    int checks = 0;
    int errors = 0;
    int overlap_seen = 0;

    // Vector fields: {pwm, sw_low, lsg_low, hold, force, tristate, exp_hi, exp_lo}
    localparam logic [7:0] VEC [NV] = '{
        8'b0_1_1_0_0_0_0_1,  // 0  R1 low side after reset
        8'b1_0_1_0_0_0_1_0,  // 1  R2 high side
        8'b0_0_1_0_0_0_0_0,  // 2  R1 waiting on switch node
        8'b0_1_1_0_0_0_0_1,  // 3  R1 switch node fell
        8'b0_1_0_0_0_0_0_1,  // 4  R8 low side kept
        8'b1_1_0_0_0_0_0_0,  // 5  R2 waiting on low gate
        8'b1_0_1_0_0_0_1_0,  // 6  R2 gate discharged
        8'b1_0_1_0_1_0_0_0,  // 7  R5 force waits on switch node
        8'b1_1_1_0_1_0_0_1,  // 8  R5 force low side
        8'b1_1_1_0_1_1_0_0,  // 9  R6 tristate beats force
        8'b1_1_1_0_0_0_1_0,  // 10 R6 released
        8'b0_1_1_1_0_0_0_0,  // 11 R4 hold blocks low side
        8'b1_1_1_1_0_0_1_0,  // 12 R4 first pulse
        8'b0_1_1_1_0_0_0_1,  // 13 R4 low side after pulse
        8'b0_1_1_0_0_0_0_1,  // 14 R4 hold ends
        8'b0_1_1_1_0_0_0_0,  // 15 R4 re-armed hold
        8'b0_1_1_1_1_0_0_1,  // 16 R5 force overrides hold
        8'b0_1_1_1_0_0_0_0,  // 17 R4 blocked again
        8'b1_1_1_1_0_0_1_0,  // 18 R4 pulse
        8'b0_1_1_0_0_0_0_1   // 19 R4 normal
    };
    localparam int REQ [NV] = '{1,2,1,1,8,2,2,5,5,6,6,4,4,4,4,4,5,4,4,4};

    dt_gate_sequencer #(.WD_CYCLES(WD)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwm_cmd      (pwm_cmd),
        .sw_node_low  (sw_node_low),
        .lo_gate_low  (lo_gate_low),
        .ss_hold      (ss_hold),
        .prot_force_lo(prot_force_lo),
        .prot_tristate(prot_tristate),
        .hi_gate_en   (hi),
        .lo_gate_en   (lo)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Overlap monitor for R7.
    always @(negedge clk) if (rst_n === 1'b1 && hi === 1'b1 && lo === 1'b1) overlap_seen++;

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic eh, input logic el);
        checks++;
        if (hi !== eh || lo !== el) begin
            errors++;
            $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", tag, hi, lo, eh, el);
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int bad;
        @(negedge clk);
        step(3);
        chk("R9 reset state", 1'b0, 1'b0);
        rst_n = 1'b1;

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            {pwm_cmd, sw_node_low, lo_gate_low, ss_hold, prot_force_lo, prot_tristate} = VEC[i][7:2];
            step(SETTLE);
            chk($sformatf("R%0d vector %0d", REQ[i], i), VEC[i][1], VEC[i][0]);
        end

        // R1: falling command with switch-node handshake.
        pwm_cmd = 1'b1; sw_node_low = 1'b0; lo_gate_low = 1'b1;
        step(5);   chk("R1 setup high side", 1'b1, 1'b0);
        pwm_cmd = 1'b0;
        step(1);   chk("R1 high side off one edge", 1'b0, 1'b0);
        sw_node_low = 1'b1;
        step(2);   chk("R1 low side not before third edge", 1'b0, 1'b0);
        step(1);   chk("R1 low side on third edge", 1'b0, 1'b1);

        // R2: rising command with low-gate handshake.
        lo_gate_low = 1'b0;
        step(5);   chk("R2 setup low side", 1'b0, 1'b1);
        pwm_cmd = 1'b1;
        step(1);   chk("R2 low side off one edge", 1'b0, 1'b0);
        lo_gate_low = 1'b1;
        step(2);   chk("R2 high side not before third edge", 1'b0, 1'b0);
        step(1);   chk("R2 high side on third edge", 1'b1, 1'b0);

        // R3: switch node never falls; timeout turns the low side on.
        sw_node_low = 1'b0;
        step(5);   chk("R3 setup high side", 1'b1, 1'b0);
        pwm_cmd = 1'b0;
        step(WD);  chk("R3 low side not before timeout", 1'b0, 1'b0);
        step(1);   chk("R3 low side at timeout", 1'b0, 1'b1);

        // R6: tristate acts within the cycle and beats the command.
        prot_tristate = 1'b1;
        #1;        chk("R6 low side cut same cycle", 1'b0, 1'b0);
        @(negedge clk);
        pwm_cmd = 1'b1; lo_gate_low = 1'b1;
        step(5);   chk("R6 tristate beats high command", 1'b0, 1'b0);
        prot_tristate = 1'b0;
        step(5);   chk("R6 restart after release", 1'b1, 1'b0);
        prot_tristate = 1'b1;
        #1;        chk("R6 high side cut same cycle", 1'b0, 1'b0);
        @(negedge clk);
        prot_tristate = 1'b0; pwm_cmd = 1'b0; sw_node_low = 1'b1;

        // R8: 0 % duty holds the low side.
        step(5);
        bad = 0;
        for (int k = 0; k < 100; k++) begin
            step(1);
            if (lo !== 1'b1 || hi !== 1'b0) bad++;
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL R8 zero duty: mismatched cycles=%0d expected=0", bad);
        end

        // R8: 100 % duty holds the high side.
        pwm_cmd = 1'b1;
        step(5);
        bad = 0;
        for (int k = 0; k < 100; k++) begin
            step(1);
            if (hi !== 1'b1 || lo !== 1'b0) bad++;
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL R8 full duty: mismatched cycles=%0d expected=0", bad);
        end

        // R9: reset in the middle of a high-side phase.
        rst_n = 1'b0;
        step(1);   chk("R9 reset clears outputs", 1'b0, 1'b0);
        rst_n = 1'b1;
        step(2);

        // R7: no cycle with both enables.
        checks++;
        if (overlap_seen != 0) begin
            errors++;
            $display("FAIL R7 overlap: cycles=%0d expected=0", overlap_seen);
        end

        summary();
        $finish;
    end

endmodule